// File: doc/BRIEF.md
# General-Purpose I/O Port with Change Interrupt

This block is one memory-mapped I/O port of up to `W` pins. Software sets each pin's direction, writes the value the pin drives, and reads back either the actual pin levels or the driven value. Incoming pin levels pass through a two-flop synchronizer before software or the change logic sees them. One pin position is input-only: its driver never turns on.

A change detector watches the synchronized levels of pins that are inputs and individually enabled. It compares them against a reference copy that is taken each time software reads the pin-level register. Any difference, while the global enable is on, sets a sticky flag. The interrupt line is the flag gated by the global enable. Software clears the flag by writing 0 to its status bit.

Register map (3-bit address, `W`-bit data): 0 direction, 1 pin levels (a write goes to the latch), 2 output latch, 3 per-pin change enables, 4 control/status (bit 0 global enable, bit 1 change flag). Other addresses read as 0.

Top module: `gpio_chg_port`

## Requirements
- R1: A direction bit of 1 makes the pin an input with `pin_oe` low. A direction bit of 0 drives `pin_oe` high, and `pin_out` on that pin carries the latch bit. Direction is written and read at address 0.
- R2: A write to address 1 or address 2 loads the output latch. A read of address 2 returns the latch, whatever the pin levels are.
- R3: A read of address 1 returns the pin levels after a two-flop synchronizer. Read data appears on `rdata` one cycle after the `rd_en` cycle. Unmapped addresses read as 0.
- R4: Bit 3 is input-only. `pin_oe[3]` is never high, and its direction bit always reads 1 whatever is written to it.
- R5: After reset, direction reads all ones, the latch is 0, change enables are 0, control reads 0, `pin_oe` is 0 and `irq` is 0.
- R6: Address 3 holds one change-enable bit per pin. Only pins with a set bit can set the flag.
- R7: While control bit 0 (global enable) is 0, the flag is never set and `irq` stays low.
- R8: A pin whose direction is output never sets the flag.
- R9: On every read of address 1, the synchronized levels are copied into a reference. The flag is set when any enabled input pin differs from that reference.
- R10: The flag (control bit 1) is sticky. Writing 0 to bit 1 clears it, writing 1 leaves it unchanged, and a mismatch in the same cycle wins over the clear.
- R11: `irq` is high exactly when the flag and the global enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 3 | Register address |
| we | input | 1 | Write strobe |
| wdata | input | W | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | W | Read data, valid the cycle after `rd_en` |
| pin_in | input | W | Pin levels |
| pin_out | output | W | Driven pin values |
| pin_oe | output | W | Per-pin driver enable |
| irq | output | 1 | Change interrupt |

## Verification
The embedded assertions check four things on every cycle. First, a direction write sets the driver enables and a latch write sets the driven values. Second, a pin-level read loads the reference. Third, a mismatch under the global enable sets the flag, the flag holds unless cleared, and a clear without a mismatch empties it. Fourth, the input-only pin never drives. Some behaviour can only be shown by the bench's sweeps: that every direction pattern gives the right enables, that reads return synchronized levels after the expected latency, and that the per-pin enable and output exclusion pick the correct pin out of every pin. The same holds for the reference-based comparison after software re-reads the port.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
    localparam int AW = 3;
    localparam logic [AW-1:0] A_DIR = 3'd0;
    localparam logic [AW-1:0] A_PIN = 3'd1;
    localparam logic [AW-1:0] A_LAT = 3'd2;
    localparam logic [AW-1:0] A_IEN = 3'd3;
    localparam logic [AW-1:0] A_CTL = 3'd4;
    localparam int CTL_GIE  = 0;
    localparam int CTL_FLAG = 1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_s,
    input  logic [W-1:0] in_mask,
    input  logic [W-1:0] ien,
    input  logic         gie,
    input  logic         snap,
    input  logic         clr,
    output logic         flag,
    output logic         irq
);
    typedef struct packed {
        logic [W-1:0] ref_v;
        logic         flag;
    } det_t;

    det_t         det_d, det_q;
    logic [W-1:0] mism;
    logic         set_hit;

    always_comb begin
        mism    = (pins_s ^ det_q.ref_v) & ien & in_mask;
        set_hit = gie & (|mism);
        det_d   = det_q;
        if (snap) det_d.ref_v = pins_s;
        if (set_hit)  det_d.flag = 1'b1;
        else if (clr) det_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    assign flag = det_q.flag;
    assign irq  = det_q.flag & gie;

    a_r9_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> det_q.ref_v == $past(pins_s));
    a_r9_mismatch_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (gie && |((pins_s ^ det_q.ref_v) & ien & in_mask)) |=> flag);
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_hit) |=> !flag);
    a_r7_no_set_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !gie) |=> !flag);
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
    import gpio_chg_pkg::*;
#(
    parameter int           W       = 6,
    parameter logic [W-1:0] IN_ONLY = 6'b001000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    input  logic          rd_en,
    output logic [W-1:0]  rdata,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  pin_out,
    output logic [W-1:0]  pin_oe,
    output logic          irq
);
    localparam logic [W-1:0] BIDIR = ~IN_ONLY;

    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] lat;
        logic [W-1:0] ien;
        logic         gie;
        logic [W-1:0] rdata;
    } regs_t;

    regs_t        r_d, r_q;
    logic [W-1:0] pins_s;
    logic         snap, clr, flag;
    logic [W-1:0] in_mask;

    gpio_sync #(.W(W), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pins_s)
    );

    always_comb begin
        in_mask = r_q.dir | IN_ONLY;
        snap    = rd_en && (addr == A_PIN);
        clr     = we && (addr == A_CTL) && !wdata[CTL_FLAG];
    end

    gpio_chg_detect #(.W(W)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_s  (pins_s),
        .in_mask (in_mask),
        .ien     (r_q.ien),
        .gie     (r_q.gie),
        .snap    (snap),
        .clr     (clr),
        .flag    (flag),
        .irq     (irq)
    );

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (addr)
                A_DIR:        r_d.dir = wdata | IN_ONLY;
                A_PIN, A_LAT: r_d.lat = wdata;
                A_IEN:        r_d.ien = wdata;
                A_CTL:        r_d.gie = wdata[CTL_GIE];
                default:      ;
            endcase
        end
        if (rd_en) begin
            r_d.rdata = '0;
            case (addr)
                A_DIR: r_d.rdata = r_q.dir;
                A_PIN: r_d.rdata = pins_s;
                A_LAT: r_d.rdata = r_q.lat;
                A_IEN: r_d.rdata = r_q.ien;
                A_CTL: begin
                    r_d.rdata[CTL_GIE]  = r_q.gie;
                    r_d.rdata[CTL_FLAG] = flag;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.dir   <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata   = r_q.rdata;
    assign pin_out = r_q.lat;
    assign pin_oe  = ~r_q.dir & BIDIR;

    a_r1_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_DIR) |=> pin_oe == (~$past(wdata) & BIDIR));
    a_r2_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr == A_PIN || addr == A_LAT)) |=> pin_out == $past(wdata));
    a_r4_input_only: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & IN_ONLY) == '0);
    a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_CTL && !wdata[CTL_GIE]) |=> !irq);
endmodule

// File: tb/gpio_chg_port_tb.sv
module gpio_chg_port_tb;
    localparam int W = 6;
    logic         clk = 0;
    logic         rst_n = 0;
    logic [2:0]   addr = '0;
    logic         we = 0;
    logic [W-1:0] wdata = '0;
    logic         rd_en = 0;
    logic [W-1:0] rdata;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_out, pin_oe;
    logic         irq;
    int checks = 0;
    int errors = 0;
    logic [W-1:0] rv;

    gpio_chg_port u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1;
        @(negedge clk);
        we = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        @(negedge clk);
        addr = a; rd_en = 1;
        @(negedge clk);
        rd_en = 0;
        d = rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R5 reset state
        @(negedge clk);
        check("R5 oe", pin_oe, 0);
        check("R5 irq", irq, 0);
        rd(3'd0, rv); check("R5 dir", rv, 6'h3F);
        rd(3'd2, rv); check("R5 lat", rv, 0);
        rd(3'd3, rv); check("R5 ien", rv, 0);
        rd(3'd4, rv); check("R5 ctl", rv, 0);
        rd(3'd6, rv); check("R3 unmapped", rv, 0);

        // R1 R4 sweep of every direction pattern
        for (int i = 0; i < 64; i++) begin
            wr(3'd0, 6'(i));
            wr(3'd2, 6'(i ^ 6'h15));
            check("R1 oe", pin_oe, (~(i | 8)) & 6'h3F);
            check("R1 out", pin_out, (i ^ 6'h15) & 6'h3F);
            check("R4 oe3", pin_oe[3], 0);
            rd(3'd0, rv); check("R4 dir readback", rv, (i | 8) & 6'h3F);
        end

        // R3 pin level sweep
        wr(3'd0, 6'h3F);
        for (int i = 0; i < 64; i++) begin
            pin_in = 6'(i);
            repeat (2) @(negedge clk);
            rd(3'd1, rv); check("R3 pin read", rv, i);
        end

        // R2 latch independent of pins; write via port address
        pin_in = 6'h2A;
        wr(3'd1, 6'h11);
        settle();
        rd(3'd2, rv); check("R2 lat read", rv, 6'h11);
        rd(3'd1, rv); check("R2 pin read", rv, 6'h2A);
        wr(3'd2, 6'h3C);
        rd(3'd2, rv); check("R2 lat write", rv, 6'h3C);

        // R7 global enable off
        pin_in = 0; settle();
        rd(3'd1, rv);
        wr(3'd4, 6'h0);
        wr(3'd3, 6'h3F);
        pin_in = 6'h3F; settle();
        check("R7 irq off", irq, 0);
        rd(3'd4, rv); check("R7 flag not set", rv, 0);
        pin_in = 0; settle();

        // R6 R9 per-pin enable sweep
        wr(3'd0, 6'h3F);
        wr(3'd4, 6'h1);
        for (int p = 0; p < W; p++) begin
            wr(3'd3, 6'(1 << p));
            for (int q = 0; q < W; q++) begin
                pin_in = 6'(1 << q); settle();
                check("R6 per-pin enable", irq, (p == q));
                pin_in = 0; settle();
                rd(3'd1, rv);
                wr(3'd4, 6'h1);
            end
        end

        // R8 output pins excluded (bit 3 input-only still counts)
        for (int p = 0; p < W; p++) begin
            wr(3'd0, 6'h3F & ~6'(1 << p));
            wr(3'd3, 6'(1 << p));
            pin_in = 6'(1 << p); settle();
            check("R8 output excluded", irq, (p == 3));
            pin_in = 0; settle();
            rd(3'd1, rv);
            wr(3'd4, 6'h1);
        end
        wr(3'd0, 6'h3F);

        // R9 reference comes from the last port read
        wr(3'd3, 6'h3F);
        pin_in = 6'h05; settle();
        rd(3'd1, rv);
        wr(3'd4, 6'h1);
        settle();
        check("R9 match no flag", irq, 0);
        pin_in = 6'h04; settle();
        check("R9 mismatch sets", irq, 1);
        // R10 clear loses to a live mismatch
        wr(3'd4, 6'h1);
        rd(3'd4, rv); check("R10 set wins", rv, 6'h3);
        rd(3'd1, rv);
        wr(3'd4, 6'h1);
        rd(3'd4, rv); check("R10 clear", rv, 6'h1);
        // R10 sticky after pins return
        pin_in = 6'h00; settle();
        pin_in = 6'h04; settle();
        check("R10 sticky", irq, 1);
        wr(3'd4, 6'h3);
        rd(3'd4, rv); check("R10 write 1 keeps", rv, 6'h3);
        // R11 irq gated by global enable
        wr(3'd4, 6'h2);
        check("R11 irq gated", irq, 0);
        rd(3'd4, rv); check("R11 flag kept", rv, 6'h2);
        wr(3'd4, 6'h3);
        check("R11 irq on", irq, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule